// File: doc/BRIEF.md
# Transponder Readout Sequencer

This block decides, one bit period at a time, what a contactless identification tag sends back to its reader. After reset it stays silent for a fixed settling window. At the end of that window it latches the configuration word held in memory block 0. It then walks the user blocks from block 1 up to a programmable last block and presents their payload bits one per cycle to the modulator. After the last block it wraps back to block 1. The lock bit of every block (bit 0) is never sent.

Optional synchronisation patterns are raised on a separate terminator output. A block marker comes before each block. A sequence marker, twice as long, follows the last block. The configuration word is re-latched every time a block begins, so a corrupted copy is repaired on the next block. Strobes from the write decoder and from the programming controller restart the walk at a chosen block. They can also silence the tag until the next reset, or unmute a tag configured to answer only on request.

Top module: `xpdr_read_seq`

## Requirements
- R1: From reset until SETUP_CYCLES clock cycles have passed, `modEn`, `dataOut` and `termOut` are low and `memAddr` is 0. At the end of that window the configuration is taken from `modeData` and the first block begins.
- R2: The configuration fields sit at fixed bit positions of block 0: last block in bits 3:1, block-marker enable in bit 4, sequence-marker enable in bit 5, answer-on-request in bit 6. All other bits are ignored.
- R3: A block is sent as `memData[1]` through `memData[32]`, one bit per cycle on `dataOut`, with `memAddr` holding the block number. `memData[0]` is never sent. After the last block, reading wraps to block 1.
- R4: When the last-block field is 0, block 0 is sent repeatedly and no sequence marker ever appears.
- R5: With the block-marker enable set, each block is preceded by TERM_LEN cycles with `termOut` high and `dataOut` low.
- R6: With the sequence-marker enable set and a nonzero last block, 2*TERM_LEN cycles of `termOut` high follow the last block. The next block starts after them.
- R7: The configuration register is reloaded from `modeData` at the start of every block. A change to block 0 therefore takes effect at the next block boundary.
- R8: `evProgDone` restarts reading at `evAddr`. A marker comes first if either marker enable is set. When `evAddr` is 0, that block is sent under the old configuration, and the new one applies from the following block.
- R9: `evWrErr` restarts reading at block 1 under the normal marker rules. `evProgFail` restarts at `evAddr`, with the same forced marker as R8.
- R10: `evStop` drives `modEn`, `dataOut` and `termOut` low until the next reset, and a later `evWake` does not undo it.
- R11: With answer-on-request set, outputs stay silent after the settling window until `evWake` arrives. The walk keeps its position while muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on) |
| memData | input | 33 | Contents of the block at `memAddr`, lock bit in bit 0 |
| modeData | input | 33 | Current contents of block 0 |
| evWrErr | input | 1 | One-cycle strobe: received write sequence was invalid |
| evProgDone | input | 1 | One-cycle strobe: block `evAddr` was programmed |
| evProgFail | input | 1 | One-cycle strobe: programming of `evAddr` was refused |
| evStop | input | 1 | One-cycle strobe: stop command received |
| evWake | input | 1 | One-cycle strobe: valid request with password received |
| evAddr | input | 3 | Block addressed by the write or programming event |
| memAddr | output | 3 | Block currently being read |
| dataOut | output | 1 | Serial payload bit toward the modulator |
| termOut | output | 1 | High while a block or sequence marker is sent |
| modEn | output | 1 | Modulator enable |

## Verification
The bench compares every cycle against an independent walk model. This catches an off-by-one that leaks the lock bit or drops bit 32. It also catches a wrap that goes to block 0 instead of block 1, or a sequence marker that appears when the last-block field is 0.

Three kinds of restart are driven: after a write error, after a completed programming of a user block, and after programming of block 0 itself. A design that applies the new configuration at once would change the marker or wrap behaviour one block too early. The bench further changes block 0 in the middle of a block to confirm the refresh happens only at the boundary. It also verifies that a wake strobe cannot revive a stopped tag.

// File: rtl/xpdr_read_seq_pkg.sv
package xpdr_read_seq_pkg;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_TERM  = 2'd1,
    PH_DATA  = 2'd2,
    PH_SEQ   = 2'd3
  } seqPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enter;     // start a new block at enterAddr
    logic loadMode;  // latch configuration from block 0 with the entry
    logic incBit;    // advance to next payload bit
  } dpCmd_t;

endpackage

// File: rtl/xpdr_read_seq_dp.sv
module xpdr_read_seq_dp
  import xpdr_read_seq_pkg::*;
#(
  parameter int unsigned BLK_BITS = 33,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [ADDR_W-1:0]   enterAddr,
  input  logic [BLK_BITS-1:0] modeData,
  input  logic [BLK_BITS-1:0] memData,
  output logic [ADDR_W-1:0]   curBlk,
  output logic [CNT_W-1:0]    bitCnt,
  output logic                lastBit,
  output logic                txBit,
  output logic [ADDR_W-1:0]   regMaxBlk,
  output logic                regUseBt,
  output logic                regUseSt,
  output logic                regAor,
  output logic [ADDR_W-1:0]   nowMaxBlk,
  output logic                nowUseBt,
  output logic                nowUseSt
);

  localparam int unsigned MB_LSB  = 1;
  localparam int unsigned BT_BIT  = MB_LSB + ADDR_W;
  localparam int unsigned ST_BIT  = BT_BIT + 1;
  localparam int unsigned AOR_BIT = ST_BIT + 1;
  localparam int unsigned LAST_IX = BLK_BITS - 1;

  logic nowAor;

  assign nowMaxBlk = modeData[MB_LSB +: ADDR_W];
  assign nowUseBt  = modeData[BT_BIT];
  assign nowUseSt  = modeData[ST_BIT];
  assign nowAor    = modeData[AOR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regMaxBlk <= '0;
      regUseBt  <= 1'b0;
      regUseSt  <= 1'b0;
      regAor    <= 1'b0;
    end else if (cmd.enter && cmd.loadMode) begin
      regMaxBlk <= nowMaxBlk;
      regUseBt  <= nowUseBt;
      regUseSt  <= nowUseSt;
      regAor    <= nowAor;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBlk <= '0;
      bitCnt <= '0;
    end else if (cmd.enter) begin
      curBlk <= enterAddr;
      bitCnt <= CNT_W'(1);
    end else if (cmd.incBit) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign lastBit = (bitCnt == CNT_W'(LAST_IX));
  assign txBit   = memData[bitCnt];

  // R3: a payload bit index never wraps past the last data bit
  p_bit_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incBit && !cmd.enter) |-> !lastBit);

endmodule

// File: rtl/xpdr_read_seq_ctrl.sv
module xpdr_read_seq_ctrl
  import xpdr_read_seq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned TERM_LEN     = 4,
  parameter int unsigned SETUP_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evWrErr,
  input  logic              evProgDone,
  input  logic              evProgFail,
  input  logic              evStop,
  input  logic              evWake,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [ADDR_W-1:0] curBlk,
  input  logic              lastBit,
  input  logic              txBit,
  input  logic [ADDR_W-1:0] regMaxBlk,
  input  logic              regUseBt,
  input  logic              regUseSt,
  input  logic              regAor,
  input  logic [ADDR_W-1:0] nowMaxBlk,
  input  logic              nowUseBt,
  input  logic              nowUseSt,
  output dpCmd_t            cmd,
  output logic [ADDR_W-1:0] enterAddr,
  output seqPhase_e         phase,
  output logic              modEn,
  output logic              dataOut,
  output logic              termOut
);

  localparam int unsigned SC_W    = $clog2(SETUP_CYCLES + 1);
  localparam int unsigned SEQ_LEN = 2 * TERM_LEN;
  localparam int unsigned TC_W    = $clog2(SEQ_LEN + 1);

  seqPhase_e         nextPhase;
  logic [SC_W-1:0]   setupCnt;
  logic [TC_W-1:0]   termCnt, termNext;
  logic              stopped, awake;
  logic              doEnter, forceTerm, refresh, anyEv;
  logic              effBt, effSt;
  logic [ADDR_W-1:0] firstBlk;

  assign anyEv    = (evWrErr || evProgDone || evProgFail) && (phase != PH_SETUP);
  assign firstBlk = (regMaxBlk == '0) ? '0 : ADDR_W'(1);

  always_comb begin
    doEnter   = 1'b0;
    forceTerm = 1'b0;
    refresh   = 1'b1;
    enterAddr = '0;
    nextPhase = phase;
    termNext  = ((phase == PH_TERM) || (phase == PH_SEQ)) ? termCnt + TC_W'(1) : '0;
    cmd       = '0;
    unique case (phase)
      PH_SETUP: begin
        if (setupCnt == SC_W'(SETUP_CYCLES - 1)) begin
          doEnter   = 1'b1;
          enterAddr = (nowMaxBlk == '0) ? '0 : ADDR_W'(1);
        end
      end
      PH_TERM: begin
        if (termCnt == TC_W'(TERM_LEN - 1)) nextPhase = PH_DATA;
      end
      PH_DATA: begin
        if (!lastBit) begin
          cmd.incBit = 1'b1;
        end else if (curBlk >= regMaxBlk) begin
          if (regUseSt && (regMaxBlk != '0)) begin
            nextPhase = PH_SEQ;
            termNext  = '0;
          end else begin
            doEnter   = 1'b1;
            enterAddr = firstBlk;
          end
        end else begin
          doEnter   = 1'b1;
          enterAddr = curBlk + ADDR_W'(1);
        end
      end
      PH_SEQ: begin
        if (termCnt == TC_W'(SEQ_LEN - 1)) begin
          doEnter   = 1'b1;
          enterAddr = firstBlk;
        end
      end
      default: ;
    endcase

    // restart requests override the normal walk
    if (phase != PH_SETUP) begin
      if (evWrErr) begin
        doEnter   = 1'b1;
        enterAddr = ADDR_W'(1);
      end else if (evProgDone) begin
        doEnter   = 1'b1;
        forceTerm = 1'b1;
        enterAddr = evAddr;
        refresh   = (evAddr != '0);
      end else if (evProgFail) begin
        doEnter   = 1'b1;
        forceTerm = 1'b1;
        enterAddr = evAddr;
      end
    end

    effBt = refresh ? nowUseBt : regUseBt;
    effSt = refresh ? nowUseSt : regUseSt;
    if (doEnter) begin
      cmd.enter    = 1'b1;
      cmd.loadMode = refresh;
      cmd.incBit   = 1'b0;
      termNext     = '0;
      nextPhase    = (effBt || (forceTerm && effSt)) ? PH_TERM : PH_DATA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_SETUP;
      termCnt  <= '0;
      setupCnt <= '0;
      stopped  <= 1'b0;
      awake    <= 1'b0;
    end else begin
      phase   <= nextPhase;
      termCnt <= termNext;
      if (phase == PH_SETUP) setupCnt <= setupCnt + SC_W'(1);
      if (evStop && (phase != PH_SETUP)) stopped <= 1'b1;
      if (evWake && (phase != PH_SETUP)) awake   <= 1'b1;
    end
  end

  assign modEn   = (phase != PH_SETUP) && !stopped && (!regAor || awake);
  assign dataOut = modEn && (phase == PH_DATA) && txBit;
  assign termOut = modEn && ((phase == PH_TERM) || (phase == PH_SEQ));

  // R10: once stopped, the modulator stays off until reset
  p_stop_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !modEn && stopped |=> !modEn);

  // R4: no sequence marker while only block 0 is exposed
  p_zero_no_seq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SEQ) |-> (regMaxBlk != '0));

  // R5: a block marker lasts exactly TERM_LEN periods
  p_term_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TERM && termCnt == TC_W'(TERM_LEN - 1) && !anyEv) |=> (phase == PH_DATA));

  // R3: after the last block without sequence marker the walk returns to block 1
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && lastBit && curBlk >= regMaxBlk && regMaxBlk != '0
     && !regUseSt && !anyEv) |=> (curBlk == ADDR_W'(1)));

  // R9: a write error restarts at block 1
  p_wrerr_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evWrErr && phase != PH_SETUP) |=> (curBlk == ADDR_W'(1)));

endmodule

// File: rtl/xpdr_read_seq.sv
module xpdr_read_seq
  import xpdr_read_seq_pkg::*;
#(
  parameter int unsigned N_BLK        = 8,
  parameter int unsigned BLK_BITS     = 33,
  parameter int unsigned TERM_LEN     = 4,
  parameter int unsigned SETUP_CYCLES = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [BLK_BITS-1:0]        memData,
  input  logic [BLK_BITS-1:0]        modeData,
  input  logic                       evWrErr,
  input  logic                       evProgDone,
  input  logic                       evProgFail,
  input  logic                       evStop,
  input  logic                       evWake,
  input  logic [$clog2(N_BLK)-1:0]   evAddr,
  output logic [$clog2(N_BLK)-1:0]   memAddr,
  output logic                       dataOut,
  output logic                       termOut,
  output logic                       modEn
);

  localparam int unsigned ADDR_W = $clog2(N_BLK);
  localparam int unsigned CNT_W  = $clog2(BLK_BITS);

  dpCmd_t            cmd;
  seqPhase_e         phase;
  logic [ADDR_W-1:0] enterAddr, curBlk, regMaxBlk, nowMaxBlk;
  logic [CNT_W-1:0]  bitCnt;
  logic              lastBit, txBit;
  logic              regUseBt, regUseSt, regAor, nowUseBt, nowUseSt;

  xpdr_read_seq_dp #(
    .BLK_BITS(BLK_BITS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .enterAddr(enterAddr),
    .modeData(modeData), .memData(memData),
    .curBlk(curBlk), .bitCnt(bitCnt), .lastBit(lastBit), .txBit(txBit),
    .regMaxBlk(regMaxBlk), .regUseBt(regUseBt), .regUseSt(regUseSt), .regAor(regAor),
    .nowMaxBlk(nowMaxBlk), .nowUseBt(nowUseBt), .nowUseSt(nowUseSt)
  );

  xpdr_read_seq_ctrl #(
    .ADDR_W(ADDR_W), .TERM_LEN(TERM_LEN), .SETUP_CYCLES(SETUP_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evWrErr(evWrErr), .evProgDone(evProgDone), .evProgFail(evProgFail),
    .evStop(evStop), .evWake(evWake), .evAddr(evAddr),
    .curBlk(curBlk), .lastBit(lastBit), .txBit(txBit),
    .regMaxBlk(regMaxBlk), .regUseBt(regUseBt), .regUseSt(regUseSt), .regAor(regAor),
    .nowMaxBlk(nowMaxBlk), .nowUseBt(nowUseBt), .nowUseSt(nowUseSt),
    .cmd(cmd), .enterAddr(enterAddr), .phase(phase),
    .modEn(modEn), .dataOut(dataOut), .termOut(termOut)
  );

  assign memAddr = curBlk;

  // R3: the lock bit (index 0) is never the bit on air
  p_lock_never_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (bitCnt != '0 && bitCnt <= CNT_W'(BLK_BITS - 1)));

  // R1: the first block starts only once the settling window is over
  p_setup_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETUP) |-> (!termOut && !dataOut && memAddr == '0));

endmodule

// File: tb/xpdr_read_seq_bench.sv
module xpdr_read_seq_bench;

  localparam int TL = 4;
  localparam int SC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [32:0] mem [8];
  logic [32:0] memData, modeData;
  logic        evWrErr = 0, evProgDone = 0, evProgFail = 0, evStop = 0, evWake = 0;
  logic [2:0]  evAddr = '0;
  logic [2:0]  memAddr;
  logic        dataOut, termOut, modEn;

  int nChecks = 0;
  int nFails  = 0;

  // independent walk model
  int mBlk, mPh, mCnt, mMb;
  bit mBt, mSt;

  always #2 clk = ~clk;

  assign memData  = mem[memAddr];
  assign modeData = mem[0];

  xpdr_read_seq u_xpdr_read_seq (
    .clk(clk), .rstN(rstN), .memData(memData), .modeData(modeData),
    .evWrErr(evWrErr), .evProgDone(evProgDone), .evProgFail(evProgFail),
    .evStop(evStop), .evWake(evWake), .evAddr(evAddr),
    .memAddr(memAddr), .dataOut(dataOut), .termOut(termOut), .modEn(modEn)
  );

  function automatic logic [32:0] mkMode(int mb, bit bt, bit st, bit aor);
    logic [32:0] w;
    w = 33'h1_2340_0000;          // unrelated bits set, must be ignored (R2)
    w[3:1] = mb[2:0];
    w[4] = bt;
    w[5] = st;
    w[6] = aor;
    return w;
  endfunction

  task automatic mEnter(int b, bit force_, bit refresh);
    if (refresh) begin
      mMb = int'(mem[0][3:1]);
      mBt = mem[0][4];
      mSt = mem[0][5];
    end
    mBlk = b;
    if (mBt || (force_ && mSt)) begin mPh = 0; mCnt = 0; end
    else begin mPh = 1; mCnt = 1; end
  endtask

  task automatic mStep();
    int first;
    first = (mMb == 0) ? 0 : 1;
    case (mPh)
      0: begin
        if (mCnt == TL - 1) begin mPh = 1; mCnt = 1; end else mCnt++;
      end
      1: begin
        if (mCnt == 32) begin
          if (mBlk >= mMb) begin
            if (mSt && mMb != 0) begin mPh = 2; mCnt = 0; end
            else mEnter(first, 0, 1);
          end else mEnter(mBlk + 1, 0, 1);
        end else mCnt++;
      end
      default: begin
        if (mCnt == 2 * TL - 1) mEnter(first, 0, 1); else mCnt++;
      end
    endcase
  endtask

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {addr,term,data,en} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // compare n cycles against the model; quiet = outputs muted
  task automatic runCheck(int n, bit quiet, string req);
    for (int i = 0; i < n; i++) begin
      logic [5:0] e;
      if (quiet) e = {mBlk[2:0], 3'b000};
      else if (mPh == 1) e = {mBlk[2:0], 1'b0, mem[mBlk][mCnt], 1'b1};
      else e = {mBlk[2:0], 1'b1, 1'b0, 1'b1};
      check(req, {memAddr, termOut, dataOut, modEn}, e);
      mStep();
      @(negedge clk);
    end
  endtask

  task automatic doReset(logic [32:0] mode, string req);
    int first;
    mem[0] = mode;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < SC - 1; i++) begin
      @(negedge clk);
      check(req, {memAddr, termOut, dataOut, modEn}, 6'b000000);
    end
    @(negedge clk);
    first = (mode[3:1] == 3'd0) ? 0 : 1;
    mEnter(first, 0, 1);
  endtask

  // kind: 0 wrErr, 1 progDone, 2 progFail, 3 stop, 4 wake
  task automatic pulse(int kind, int addr);
    evAddr = addr[2:0];
    case (kind)
      0: evWrErr = 1; 1: evProgDone = 1; 2: evProgFail = 1;
      3: evStop = 1; default: evWake = 1;
    endcase
    @(negedge clk);
    {evWrErr, evProgDone, evProgFail, evStop, evWake} = '0;
    case (kind)
      0: mEnter(1, 0, 1);
      1: mEnter(addr, 1, addr != 0);
      2: mEnter(addr, 1, 1);
      default: mStep();
    endcase
  endtask

  task automatic t_plain();       // R1 R2 R3
    doReset(mkMode(2, 0, 0, 0), "R1");
    runCheck(140, 0, "R3");
  endtask

  task automatic t_blockMarker(); // R5
    doReset(mkMode(3, 1, 0, 0), "R1");
    runCheck(170, 0, "R5");
  endtask

  task automatic t_seqMarker();   // R6
    doReset(mkMode(2, 1, 1, 0), "R1");
    runCheck(200, 0, "R6");
    doReset(mkMode(1, 0, 1, 0), "R1");
    runCheck(100, 0, "R6");
  endtask

  task automatic t_zero();        // R4
    doReset(mkMode(0, 1, 1, 0), "R1");
    runCheck(150, 0, "R4");
  endtask

  task automatic t_refresh();     // R7
    doReset(mkMode(2, 0, 0, 0), "R1");
    runCheck(10, 0, "R7");
    mem[0] = mkMode(1, 1, 0, 0);
    runCheck(160, 0, "R7");
  endtask

  task automatic t_progDone();    // R8
    doReset(mkMode(3, 0, 1, 0), "R1");
    runCheck(12, 0, "R8");
    pulse(1, 2);
    runCheck(140, 0, "R8");
    // block 0 rewritten: old mode for that block, new afterwards
    doReset(mkMode(2, 0, 0, 0), "R1");
    runCheck(20, 0, "R8");
    mem[0] = mkMode(1, 1, 0, 0);
    pulse(1, 0);
    runCheck(150, 0, "R8");
  endtask

  task automatic t_errors();      // R9
    doReset(mkMode(3, 1, 0, 0), "R1");
    runCheck(60, 0, "R9");
    pulse(0, 5);
    runCheck(50, 0, "R9");
    pulse(2, 3);
    runCheck(60, 0, "R9");
  endtask

  task automatic t_stop();        // R10
    doReset(mkMode(2, 1, 0, 0), "R1");
    runCheck(30, 0, "R10");
    pulse(3, 0);
    runCheck(50, 1, "R10");
    pulse(4, 0);
    runCheck(50, 1, "R10");
    doReset(mkMode(2, 1, 0, 0), "R10");
    runCheck(40, 0, "R10");
  endtask

  task automatic t_aor();         // R11
    doReset(mkMode(2, 0, 1, 1), "R1");
    runCheck(60, 1, "R11");
    pulse(4, 0);
    runCheck(120, 0, "R11");
  endtask

  initial begin
    for (int b = 0; b < 8; b++)
      mem[b] = {32'hA5C3_0F96 ^ (32'(b) * 32'h1357_9BDF), 1'b1};
    mem[0] = mkMode(2, 0, 0, 0);
    @(negedge clk);
    t_plain();
    t_blockMarker();
    t_seqMarker();
    t_zero();
    t_refresh();
    t_progDone();
    t_errors();
    t_stop();
    t_aor();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule